// File: doc/BRIEF.md
# Approximate CORDIC Sine/Cosine Generator

This block turns an angle in the first quadrant into fixed-point cosine and sine. The angle is an unsigned count of tenths of a degree. A range decoder sorts it into one of six angle bands. The band gives a 4-bit control code, and that code picks three things. First, the vector the pipeline starts from: the unit vector (x = 1, y = 0) already turned to the lower edge of the band. This is resolved in one step, with no loop. Second, which of two shift schedules the micro-rotations use. Third, the matching gain-correction constant.

The angle left over after that coarse step is removed by a fixed number of micro-rotations. Each one has a sign of +1 or −1 and uses only shifts and additions, with no multiplier. Every x/y addition goes through an adder that can be built exact or approximate, chosen by a parameter. The approximate build replaces the low bits of each sum with a bitwise OR.

One angle can be accepted on every clock. Each result leaves the block exactly STAGES+1 rising edges after its input was taken. It carries cosine, sine, the band code and an over-range flag. An angle above 90.0° raises the flag and is computed as 90.0°.

Top module: `sincos_approx_cordic`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `in_ready` are both 0.
- R2: `out_band` carries the code of the band the effective angle A (in tenths) falls into:
  - A ≤ 100 gives 4'b1000
  - 101–200 gives 4'b1001
  - 201–400 gives 4'b1010
  - 401–600 gives 4'b1100
  - 601–800 gives 4'b1101
  - 801–900 gives 4'b1110
- R3: `out_cos`, read as signed Q1.14 (value = code / 16384), is within 0.01 of cos(A/10 degrees) for every A from 0 to 900.
- R4: `out_sin`, read as signed Q1.14, is within 0.01 of sin(A/10 degrees) for every A from 0 to 900.
- R5: An input accepted at a rising edge (`in_valid` and `in_ready` both high) produces exactly one `out_valid` cycle, STAGES+1 rising edges later, counting the accepting edge. Results keep the order of their inputs.
- R6: An input above 900 gives `out_err` = 1. Its result matches 90.0° under R2–R4. An input of 900 or below gives `out_err` = 0.
- R7: A cycle with `in_valid` low adds no result, whatever value `in_angle` holds.
- R8: Inputs presented on consecutive cycles are all accepted, and their results come out on consecutive cycles.
- R9: From the second rising edge after reset is released, `in_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Angle on `in_angle` is offered |
| in_ready | output | 1 | Block takes an angle this cycle |
| in_angle | input | AW | Unsigned angle in tenths of a degree |
| out_valid | output | 1 | Result outputs hold a new result |
| out_cos | output | DW | Cosine, signed Q1.14 |
| out_sin | output | DW | Sine, signed Q1.14 |
| out_err | output | 1 | Input angle was above 90.0° |
| out_band | output | 4 | Band control code of the effective angle |

## Verification
The cases hardest to reach from the ports are the band edges. There, one tenth of a degree moves the angle to a different start vector, shift schedule and gain constant. Here the residual rotation is at its largest (20°) or is zero, and the approximate adders have the most steps in which to build up error.

The stimulus covers this in three parts:
- every tenth from 0 to 900, back to back, so that results leave on consecutive cycles;
- each pair of values on either side of a band edge, sent again with idle gaps;
- over-range values up to the largest code `in_angle` can hold, mixed with idle cycles in which `in_angle` keeps changing.

// File: rtl/sincos_cordic_pkg.sv
package sincos_cordic_pkg;

    localparam int ANG_MAX   = 900;   // 90.0 degrees in tenths
    localparam int ZFRAC     = 8;     // fraction bits of the residual angle
    localparam int RESID_MAX = 200;   // widest band, tenths
    localparam int QREF      = 14;    // fraction bits of the constants below
    localparam int KW        = 15;    // width of the gain-correction constants

    typedef enum logic [3:0] {
        BAND_A = 4'b1000,
        BAND_B = 4'b1001,
        BAND_C = 4'b1010,
        BAND_D = 4'b1100,
        BAND_E = 4'b1101,
        BAND_F = 4'b1110
    } band_e;

    // Lower edge of each band, in tenths of a degree.
    function automatic int band_floor(input band_e b);
        case (b)
            BAND_A:  return 0;
            BAND_B:  return 100;
            BAND_C:  return 200;
            BAND_D:  return 400;
            BAND_E:  return 600;
            default: return 800;
        endcase
    endfunction

    // cos of the band floor, Q.14
    function automatic int floor_cos(input band_e b);
        case (b)
            BAND_A:  return 16384;
            BAND_B:  return 16135;
            BAND_C:  return 15396;
            BAND_D:  return 12551;
            BAND_E:  return 8192;
            default: return 2845;
        endcase
    endfunction

    // sin of the band floor, Q.14
    function automatic int floor_sin(input band_e b);
        case (b)
            BAND_A:  return 0;
            BAND_B:  return 2845;
            BAND_C:  return 5604;
            BAND_D:  return 10531;
            BAND_E:  return 14189;
            default: return 16135;
        endcase
    endfunction

    // Ten-degree-wide bands start their shifts at 3, twenty-degree-wide ones at 2.
    function automatic logic narrow_band(input band_e b);
        return (b == BAND_A) || (b == BAND_B) || (b == BAND_F);
    endfunction

    // atan(2^-k) expressed in tenths of a degree times 2^ZFRAC.
    function automatic int atan_step(input int k);
        case (k)
            2:  return 35933;
            3:  return 18240;
            4:  return 9155;
            5:  return 4582;
            6:  return 2292;
            7:  return 1146;
            8:  return 573;
            9:  return 286;
            10: return 143;
            11: return 72;
            12: return 36;
            13: return 18;
            14: return 9;
            15: return 4;
            default: return (146677 + (1 << (k - 1))) >> k;
        endcase
    endfunction

    function automatic int rescale(input int v, input int frac);
        if (frac >= QREF) return v <<< (frac - QREF);
        return v >>> (QREF - frac);
    endfunction

endpackage

// File: rtl/approx_ripple_add.sv
module approx_ripple_add #(
    parameter int W     = 16,
    parameter int LSBS  = 2,
    parameter int KIND  = 1     // 0: exact, 1: OR on the low LSBS bits
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum
);
    generate
        if (KIND == 0 || LSBS == 0) begin : g_exact
            assign sum = a + b + W'(cin);
        end else begin : g_lower_or
            logic [LSBS-1:0]   lo;
            logic [W-LSBS-1:0] hi;
            logic              c_lo;
            always_comb begin
                lo    = a[LSBS-1:0] | b[LSBS-1:0];
                lo[0] = lo[0] | cin;
                c_lo  = a[LSBS-1] & b[LSBS-1];
                hi    = a[W-1:LSBS] + b[W-1:LSBS] + (W-LSBS)'(c_lo);
            end
            assign sum = {hi, lo};
        end
    endgenerate
endmodule

// File: rtl/angle_band_decode.sv
module angle_band_decode
    import sincos_cordic_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic [AW-1:0] angle,
    output band_e         band,
    output logic [AW-1:0] eff,
    output logic          over
);
    always_comb begin
        over = int'(angle) > ANG_MAX;
        eff  = over ? AW'(ANG_MAX) : angle;
        if (int'(eff) <= 100)      band = BAND_A;
        else if (int'(eff) <= 200) band = BAND_B;
        else if (int'(eff) <= 400) band = BAND_C;
        else if (int'(eff) <= 600) band = BAND_D;
        else if (int'(eff) <= 800) band = BAND_E;
        else                       band = BAND_F;
    end
endmodule

// File: rtl/cordic_micro_step.sv
module cordic_micro_step
    import sincos_cordic_pkg::*;
#(
    parameter int DW   = 16,
    parameter int ZW   = 18,
    parameter int IDX  = 0,
    parameter int LSBS = 2,
    parameter int KIND = 1
) (
    input  logic                 narrow,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    output logic signed [DW-1:0] x_o,
    output logic signed [DW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    localparam int SH_WIDE   = IDX + 2;
    localparam int SH_NARROW = IDX + 3;
    localparam logic signed [ZW-1:0] ANG_WIDE   = ZW'(atan_step(SH_WIDE));
    localparam logic signed [ZW-1:0] ANG_NARROW = ZW'(atan_step(SH_NARROW));

    logic                 ccw;
    logic signed [DW-1:0] x_sh, y_sh;
    logic        [DW-1:0] bx, by;
    logic signed [ZW-1:0] ang;

    always_comb begin
        ccw  = ~z_i[ZW-1];
        x_sh = narrow ? (x_i >>> SH_NARROW) : (x_i >>> SH_WIDE);
        y_sh = narrow ? (y_i >>> SH_NARROW) : (y_i >>> SH_WIDE);
        bx   = ccw ? ~y_sh : y_sh;   // x - y_sh when turning positive
        by   = ccw ? x_sh : ~x_sh;   // y + x_sh when turning positive
        ang  = narrow ? ANG_NARROW : ANG_WIDE;
        z_o  = ccw ? (z_i - ang) : (z_i + ang);
    end

    approx_ripple_add #(.W(DW), .LSBS(LSBS), .KIND(KIND)) u_add_x (
        .a(x_i), .b(bx), .cin(ccw), .sum(x_o)
    );
    approx_ripple_add #(.W(DW), .LSBS(LSBS), .KIND(KIND)) u_add_y (
        .a(y_i), .b(by), .cin(~ccw), .sum(y_o)
    );
endmodule

// File: rtl/sincos_approx_cordic.sv
module sincos_approx_cordic
    import sincos_cordic_pkg::*;
#(
    parameter int AW          = 10,
    parameter int DW          = 16,
    parameter int STAGES      = 12,
    parameter int APPROX_LSBS = 2,
    parameter int ADDER_KIND  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [AW-1:0]        in_angle,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_cos,
    output logic signed [DW-1:0] out_sin,
    output logic                 out_err,
    output logic [3:0]           out_band
);
    localparam int FRAC = DW - 2;
    localparam int ZW   = $clog2(RESID_MAX << ZFRAC) + 2;
    localparam int WIDE = DW + KW + 1;
    // reciprocal gain of the micro-rotations, Q.14, for start shift 2 and 3
    localparam logic [KW-1:0] KINV_WIDE   = 15'd15731;
    localparam logic [KW-1:0] KINV_NARROW = 15'd16215;

    typedef struct packed {
        logic                 vld;
        logic                 err;
        band_e                band;
        logic                 narrow;
        logic signed [DW-1:0] x;
        logic signed [DW-1:0] y;
        logic signed [ZW-1:0] z;
    } pipe_t;

    typedef struct packed {
        logic                  rdy;
        pipe_t [STAGES-1:0]    pipe;
        logic                  ovld;
        logic                  oerr;
        band_e                 oband;
        logic signed [DW-1:0]  ocos;
        logic signed [DW-1:0]  osin;
    } state_t;

    state_t s_d, s_q;

    band_e         dec_band;
    logic [AW-1:0] dec_eff;
    logic          dec_over;
    logic          accept;

    logic signed [DW-1:0] step_x [STAGES];
    logic signed [DW-1:0] step_y [STAGES];
    logic signed [ZW-1:0] step_z [STAGES];
    logic signed [ZW-1:0] z_final_unused;

    logic [KW-1:0]          kinv;
    logic signed [WIDE-1:0] cacc, sacc;

    angle_band_decode #(.AW(AW)) u_decode (
        .angle(in_angle), .band(dec_band), .eff(dec_eff), .over(dec_over)
    );

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_step
            cordic_micro_step #(
                .DW(DW), .ZW(ZW), .IDX(g), .LSBS(APPROX_LSBS), .KIND(ADDER_KIND)
            ) u_step (
                .narrow(s_q.pipe[g].narrow),
                .x_i(s_q.pipe[g].x), .y_i(s_q.pipe[g].y), .z_i(s_q.pipe[g].z),
                .x_o(step_x[g]), .y_o(step_y[g]), .z_o(step_z[g])
            );
        end
    endgenerate

    assign z_final_unused = step_z[STAGES-1];
    assign accept = in_valid & s_q.rdy;

    always_comb begin
        s_d     = s_q;
        s_d.rdy = 1'b1;

        // coarse rotation: band floor vector and residual, no iteration
        s_d.pipe[0].vld    = accept;
        s_d.pipe[0].err    = dec_over;
        s_d.pipe[0].band   = dec_band;
        s_d.pipe[0].narrow = narrow_band(dec_band);
        s_d.pipe[0].x      = DW'(rescale(floor_cos(dec_band), FRAC));
        s_d.pipe[0].y      = DW'(rescale(floor_sin(dec_band), FRAC));
        s_d.pipe[0].z      = ZW'((int'(dec_eff) - band_floor(dec_band)) <<< ZFRAC);

        for (int g = 1; g < STAGES; g++) begin
            s_d.pipe[g]   = s_q.pipe[g-1];
            s_d.pipe[g].x = step_x[g-1];
            s_d.pipe[g].y = step_y[g-1];
            s_d.pipe[g].z = step_z[g-1];
        end

        // gain correction by shift-add of the selected constant
        kinv = s_q.pipe[STAGES-1].narrow ? KINV_NARROW : KINV_WIDE;
        cacc = WIDE'(1 <<< (QREF - 1));
        sacc = WIDE'(1 <<< (QREF - 1));
        for (int b = 0; b < KW; b++) begin
            if (kinv[b]) begin
                cacc = cacc + (WIDE'(step_x[STAGES-1]) <<< b);
                sacc = sacc + (WIDE'(step_y[STAGES-1]) <<< b);
            end
        end
        s_d.ovld  = s_q.pipe[STAGES-1].vld;
        s_d.oerr  = s_q.pipe[STAGES-1].err;
        s_d.oband = s_q.pipe[STAGES-1].band;
        s_d.ocos  = cacc[DW+QREF-1:QREF];
        s_d.osin  = sacc[DW+QREF-1:QREF];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign in_ready  = s_q.rdy;
    assign out_valid = s_q.ovld;
    assign out_err   = s_q.oerr;
    assign out_band  = s_q.oband;
    assign out_cos   = s_q.ocos;
    assign out_sin   = s_q.osin;
endmodule

// File: rtl/sincos_cordic_props.sv
module sincos_cordic_props #(
    parameter int AW     = 10,
    parameter int DW     = 16,
    parameter int STAGES = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 in_ready,
    input logic [AW-1:0]        in_angle,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_cos,
    input logic signed [DW-1:0] out_sin,
    input logic                 out_err,
    input logic [3:0]           out_band
);
    localparam int LAT = STAGES + 1;
    localparam int ONE = 1 << (DW - 2);
    localparam int LIM = 1 << (DW - 8);

    logic [LAT-1:0] acc_sr, ovr_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_sr <= '0;
            ovr_sr <= '0;
        end else begin
            acc_sr <= {acc_sr[LAT-2:0], in_valid & in_ready};
            ovr_sr <= {ovr_sr[LAT-2:0], int'(in_angle) > 900};
        end
    end

    a_r1_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    a_r2_band_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_band inside {4'b1000, 4'b1001, 4'b1010, 4'b1100, 4'b1101, 4'b1110}));

    a_r3_cos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_cos) >= -LIM && int'(out_cos) <= ONE + LIM));

    a_r4_sin_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_sin) >= -LIM && int'(out_sin) <= ONE + LIM));

    a_r5_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == acc_sr[LAT-1]);

    a_r6_err_follows_input: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_err == ovr_sr[LAT-1]));

    a_r9_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);
endmodule

bind sincos_approx_cordic sincos_cordic_props #(
    .AW(AW), .DW(DW), .STAGES(STAGES)
) u_props (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_angle(in_angle), .out_valid(out_valid), .out_cos(out_cos),
    .out_sin(out_sin), .out_err(out_err), .out_band(out_band)
);

// File: tb/sincos_approx_cordic_bench.sv
module sincos_approx_cordic_bench;
    localparam int  AW     = 10;
    localparam int  DW     = 16;
    localparam int  STAGES = 12;
    localparam int  LAT    = STAGES + 1;
    localparam real BOUND  = 0.01;
    localparam real PI     = 3.14159265358979;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic                 in_ready;
    logic [AW-1:0]        in_angle = '0;
    logic                 out_valid;
    logic signed [DW-1:0] out_cos, out_sin;
    logic                 out_err;
    logic [3:0]           out_band;

    typedef struct { int ang; int cyc; } exp_t;
    exp_t sb[$];

    int  n_checks = 0;
    int  n_fail   = 0;
    int  cyc      = 0;
    int  n_out    = 0;
    int  n_sent   = 0;
    bit  done     = 0;

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    sincos_approx_cordic #(.AW(AW), .DW(DW), .STAGES(STAGES)) u_sincos_approx_cordic (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_angle(in_angle), .out_valid(out_valid), .out_cos(out_cos),
        .out_sin(out_sin), .out_err(out_err), .out_band(out_band)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input real act, input real exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %f expected %f", req, what, act, exp_v);
        end
    endtask

    function automatic int band_of(input int a);
        if (a <= 100) return 4'b1000;
        if (a <= 200) return 4'b1001;
        if (a <= 400) return 4'b1010;
        if (a <= 600) return 4'b1100;
        if (a <= 800) return 4'b1101;
        return 4'b1110;
    endfunction

    // driver: one angle per call, pushes the expectation
    task automatic send(input int a);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_angle = AW'(a);
        it.ang = a;
        it.cyc = cyc;
        sb.push_back(it);
        n_sent++;
    endtask

    // idle cycles with in_valid low and in_angle changing (R7)
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_angle = AW'($urandom);
        end
    endtask

    // monitor / scoreboard
    exp_t m_it;
    int   m_eff;
    real  m_rad, m_c, m_s, m_ac, m_as;
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            n_out++;
            if (sb.size() == 0) begin
                check(1'b0, "R7", "result without accepted input", 1.0, 0.0);
            end else begin
                m_it  = sb.pop_front();
                m_eff = (m_it.ang > 900) ? 900 : m_it.ang;
                m_rad = real'(m_eff) * 0.1 * PI / 180.0;
                m_c   = $cos(m_rad);
                m_s   = $sin(m_rad);
                m_ac  = real'(out_cos) / 16384.0;
                m_as  = real'(out_sin) / 16384.0;
                // R5 / R8: latency counted in rising edges
                check(cyc == m_it.cyc + LAT, "R5", "latency",
                      real'(cyc - m_it.cyc), real'(LAT));
                check(int'(out_band) == band_of(m_eff), "R2", "band code",
                      real'(out_band), real'(band_of(m_eff)));
                check((m_ac - m_c <= BOUND) && (m_c - m_ac <= BOUND), "R3", "cosine",
                      m_ac, m_c);
                check((m_as - m_s <= BOUND) && (m_s - m_as <= BOUND), "R4", "sine",
                      m_as, m_s);
                check(out_err == (m_it.ang > 900), "R6", "over-range flag",
                      real'(out_err), real'(m_it.ang > 900));
            end
        end
    end

    initial begin
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            check(out_valid == 1'b0, "R1", "out_valid in reset", real'(out_valid), 0.0);
            check(in_ready == 1'b0, "R1", "in_ready in reset", real'(in_ready), 0.0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R9", "in_ready after reset", real'(in_ready), 1.0);

        // R3 R4 R8: full sweep in tenths, back to back
        for (int a = 0; a <= 900; a++) send(a);
        idle(LAT + 3);

        // R7: long idle, no result may appear
        for (int i = 0; i < 20; i++) begin
            idle(1);
            check(out_valid == 1'b0, "R7", "idle output", real'(out_valid), 0.0);
            check(in_ready == 1'b1, "R9", "ready held", real'(in_ready), 1.0);
        end

        // R6: over-range values with gaps
        send(901); idle(2);
        send(1023); idle(1);
        send(950); send(900); idle(3);
        send(0); idle(2);

        // R2: band edges on both sides
        for (int e = 0; e < 5; e++) begin
            int edge_v;
            edge_v = (e == 0) ? 100 : (e == 1) ? 200 : (e == 2) ? 400 : (e == 3) ? 600 : 800;
            send(edge_v); idle(1); send(edge_v + 1);
        end
        idle(LAT + 5);

        check(sb.size() == 0, "R5", "all results returned", real'(sb.size()), 0.0);
        check(n_out == n_sent, "R5", "one result per input", real'(n_out), real'(n_sent));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule